// File: doc/BRIEF.md
# Dual-Threshold Descriptor Fetch Request Scheduler

This block decides when a receive path should ask the system bus for more descriptors. It watches the number of free word slots in a descriptor FIFO and compares that count against two thresholds held in one configuration word. When the free space passes the upper threshold, the block asks for a fetch at once, even if the bus is busy. When the free space only passes the lower threshold, the block asks only after the bus has been quiet for a set number of clocks. This lets small fetches fill gaps on a lightly loaded bus, while large fetches are forced through when the FIFO is nearly empty.

A bus activity input drives an idle-run counter. An enqueue credit input holds off any request while the credit count is zero. The request leaves the block on a req/ack handshake, together with a flag that says which threshold caused it. A soft reset clears the handshake and the idle counter but leaves both thresholds as they were.

Top module: `rxd_fetch_sched`

## Requirements
- R1: After chip reset (rst_n low), cfg_rdata reads 0, fetch_req is 0 and fetch_urgent is 0.
- R2: A write sets the urgent threshold from cfg_wdata[31:16] and the relaxed threshold from cfg_wdata[15:0]. Bits 1:0 of each half are ignored on write and read back as 0, so a write of 0xFFFFFFFF reads back 0xFFFCFFFC and a write of 0x00040002 reads back 0x00040000.
- R3: A soft_rst cycle drops fetch_req in the next cycle and clears the idle count. The thresholds read back unchanged.
- R4: With fetch_req low and enq_credit nonzero, fifo_empty greater than the urgent threshold raises fetch_req in the next cycle, with fetch_urgent = 1, whatever bus_busy is.
- R5: The comparisons are strict. A free count equal to a threshold never requests.
- R6: A free count above the relaxed threshold, but not above the urgent one, requests (fetch_urgent = 0) only in a cycle that follows IDLE_LEN (default 4) consecutive clocks with bus_busy low.
- R7: Any cycle with bus_busy high restarts the idle run, so a busy clock after fewer than IDLE_LEN idle clocks prevents a relaxed request.
- R8: While enq_credit is 0, no new request is raised at either threshold.
- R9: Once fetch_req is high, it stays high until sampled together with fetch_ack. It is low in the next cycle, and it may rise again no earlier than the cycle after that.
- R10: A threshold of 0 makes any nonzero free count qualify, while a free count of 0 never does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset. Clears all state, including the thresholds |
| soft_rst | input | 1 | Synchronous soft reset. Clears the handshake and the idle count, keeps the thresholds |
| cfg_wr | input | 1 | Write strobe for the threshold word |
| cfg_wdata | input | 32 | Threshold write data: urgent in [31:16], relaxed in [15:0] |
| cfg_rdata | output | 32 | Threshold read-back |
| fifo_empty | input | CNT_W | Free word count of the descriptor FIFO |
| bus_busy | input | 1 | High in any clock with a bus transfer |
| enq_credit | input | CRED_W | Enqueue credit count. Zero holds off requests |
| fetch_req | output | 1 | Fetch request toward the bus master |
| fetch_urgent | output | 1 | With fetch_req: 1 if the urgent threshold caused the request |
| fetch_ack | input | 1 | Acknowledge of fetch_req |

## Verification
The bench targets the off-by-one edges. A free count exactly equal to a threshold must stay silent; a design using greater-or-equal would request there. An idle run of three clocks broken by a busy clock must not trigger a relaxed request; a design that counts total idle clocks instead of consecutive ones would fire too early. It also acks while the FIFO still qualifies, to catch a request that never drops or that re-fires in the same cycle. It checks that a soft reset keeps the thresholds but forgets the idle run. Finally, it writes the low bits of each threshold to catch a design that lets them through and so shifts every comparison.

// File: rtl/rxd_fetch_sched.sv
module rxd_fetch_sched #(
  parameter int CNT_W    = 16,
  parameter int CRED_W   = 4,
  parameter int IDLE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [CNT_W-1:0]  fifo_empty,
  input  logic              bus_busy,
  input  logic [CRED_W-1:0] enq_credit,
  output logic              fetch_req,
  output logic              fetch_urgent,
  input  logic              fetch_ack
);

  localparam int IW = $clog2(IDLE_LEN + 1);
  localparam int CW = (CNT_W > 16) ? CNT_W : 16;

  logic [13:0]   urg_q, rlx_q;
  logic [IW-1:0] idle_q;

  wire [15:0] urg_thr = {urg_q, 2'b00};
  wire [15:0] rlx_thr = {rlx_q, 2'b00};

  assign cfg_rdata = {urg_thr, rlx_thr};

  wire [CW-1:0] free_x   = CW'(fifo_empty);
  wire          bus_idle = (idle_q == IW'(IDLE_LEN));
  wire          have_cr  = |enq_credit;
  wire          urg_hit  = free_x > CW'(urg_thr);
  wire          rlx_hit  = bus_idle && (free_x > CW'(rlx_thr));
  wire          launch   = !fetch_req && have_cr && (urg_hit || rlx_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      urg_q <= '0;
      rlx_q <= '0;
    end else if (cfg_wr) begin
      urg_q <= cfg_wdata[31:18];
      rlx_q <= cfg_wdata[15:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idle_q <= '0;
    else if (soft_rst || bus_busy)
      idle_q <= '0;
    else if (!bus_idle)
      idle_q <= idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_req    <= 1'b0;
      fetch_urgent <= 1'b0;
    end else if (soft_rst || (fetch_req && fetch_ack)) begin
      fetch_req    <= 1'b0;
      fetch_urgent <= 1'b0;
    end else if (launch) begin
      fetch_req    <= 1'b1;
      fetch_urgent <= urg_hit;
    end
  end

endmodule

module rxd_fetch_sched_chk #(
  parameter int CNT_W  = 16,
  parameter int CRED_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic [31:0]       cfg_rdata,
  input logic [CNT_W-1:0]  fifo_empty,
  input logic              bus_busy,
  input logic [CRED_W-1:0] enq_credit,
  input logic              fetch_req,
  input logic              fetch_urgent,
  input logic              fetch_ack
);

  localparam int CW = (CNT_W > 16) ? CNT_W : 16;
  wire [CW-1:0] free_x = CW'(fifo_empty);
  wire [CW-1:0] urg_x  = CW'(cfg_rdata[31:16]);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ack && !soft_rst) |=> fetch_req);

  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack) |=> !fetch_req);

  p_credit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_req && enq_credit == '0) |=> !fetch_req);

  p_srst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!fetch_req && $stable(cfg_rdata)));

  p_urgent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_req && !soft_rst && enq_credit != '0 && free_x > urg_x)
      |=> (fetch_req && fetch_urgent));

  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_req && $past(bus_busy) && free_x <= urg_x) |=> !fetch_req);

endmodule

bind rxd_fetch_sched rxd_fetch_sched_chk #(.CNT_W(CNT_W), .CRED_W(CRED_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_rdata(cfg_rdata),
  .fifo_empty(fifo_empty), .bus_busy(bus_busy), .enq_credit(enq_credit),
  .fetch_req(fetch_req), .fetch_urgent(fetch_urgent), .fetch_ack(fetch_ack)
);

// File: tb/rxd_fetch_sched_tb.sv
`timescale 1ns/1ps
module rxd_fetch_sched_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [15:0] fifo_empty = '0;
  logic        bus_busy = 1'b0;
  logic [3:0]  enq_credit = '0;
  logic        fetch_req, fetch_urgent;
  logic        fetch_ack = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rxd_fetch_sched dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fifo_empty(fifo_empty),
    .bus_busy(bus_busy), .enq_credit(enq_credit), .fetch_req(fetch_req),
    .fetch_urgent(fetch_urgent), .fetch_ack(fetch_ack)
  );

  logic [1:0] exp_q[$];
  string      tag_q[$];

  int m_urg_thr = 0, m_rlx_thr = 0, m_run = 0;
  bit m_req = 0, m_urg = 0;

  task automatic step(input bit busy, input int free, input int cred,
                      input bit ack, input bit srst, input bit wr,
                      input logic [31:0] wd, input string tag);
    bit qualify, urgent_hit;
    @(negedge clk);
    bus_busy = busy; fifo_empty = 16'(free); enq_credit = 4'(cred);
    fetch_ack = ack; soft_rst = srst; cfg_wr = wr; cfg_wdata = wd;
    urgent_hit = free > m_urg_thr;
    qualify = (cred != 0) && (urgent_hit || (m_run >= 4 && free > m_rlx_thr));
    if (srst) begin
      m_req = 0; m_urg = 0;
    end else if (m_req && ack) begin
      m_req = 0; m_urg = 0;
    end else if (!m_req && qualify) begin
      m_req = 1; m_urg = urgent_hit;
    end
    if (srst || busy) m_run = 0;
    else if (m_run < 4) m_run++;
    if (wr) begin
      m_urg_thr = int'(wd[31:18]) * 4;
      m_rlx_thr = int'(wd[15:2]) * 4;
    end
    exp_q.push_back({m_req, m_urg});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if ({fetch_req, fetch_urgent} !== e) begin
        bad++;
        $display("FAIL %s: req/urgent actual=%b expected=%b", t,
                 {fetch_req, fetch_urgent}, e);
      end
    end
  end

  task automatic chk_reg(input logic [31:0] e, input string tag);
    total++;
    if (cfg_rdata !== e) begin
      bad++;
      $display("FAIL %s: cfg_rdata actual=%h expected=%h", tag, cfg_rdata, e);
    end
  endtask

  task automatic idle_n(input int n, input bit busy, input int free, input int cred,
                        input string tag);
    for (int i = 0; i < n; i++) step(busy, free, cred, 0, 0, 0, '0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk_reg(32'h0, "R1");
    total++;
    if (fetch_req !== 1'b0 || fetch_urgent !== 1'b0) begin
      bad++;
      $display("FAIL R1: req/urgent actual=%b expected=00", {fetch_req, fetch_urgent});
    end

    // R2: low bits of each half are dropped
    step(1, 0, 1, 0, 0, 1, 32'hFFFF_FFFF, "R2");
    step(1, 0, 1, 0, 0, 0, '0, "R2");
    chk_reg(32'hFFFC_FFFC, "R2");
    step(1, 0, 1, 0, 0, 1, 32'h0004_0002, "R2");
    step(1, 0, 1, 0, 0, 0, '0, "R2");
    chk_reg(32'h0004_0000, "R2");

    // urgent 16, relaxed 8
    step(1, 0, 1, 0, 0, 1, 32'h0010_0008, "R2");
    step(1, 0, 1, 0, 0, 0, '0, "R2");
    chk_reg(32'h0010_0008, "R2");

    // R5: equality never requests
    idle_n(4, 1, 16, 1, "R5");
    idle_n(8, 0, 8, 1, "R5");

    // R4 + R9: urgent request under traffic, held until ack
    idle_n(5, 1, 17, 1, "R4");
    idle_n(3, 1, 0, 0, "R9");
    step(1, 0, 1, 1, 0, 0, '0, "R9");
    idle_n(2, 1, 0, 1, "R9");

    // R6: relaxed request after four quiet clocks
    idle_n(8, 0, 12, 1, "R6");
    // R9: ack while still qualifying, falls then re-arms
    step(0, 12, 1, 1, 0, 0, '0, "R9");
    idle_n(3, 0, 12, 1, "R9");
    step(1, 0, 1, 1, 0, 0, '0, "R9");

    // R7: broken idle runs
    for (int k = 0; k < 3; k++) begin
      idle_n(1, 1, 12, 1, "R7");
      idle_n(3, 0, 12, 1, "R7");
    end
    idle_n(1, 1, 12, 1, "R7");

    // R8: no credit, then credit
    idle_n(4, 1, 40, 0, "R8");
    idle_n(4, 0, 12, 0, "R8");
    idle_n(2, 1, 40, 2, "R8");

    // R3: soft reset drops request, keeps thresholds, forgets idle run
    step(0, 0, 1, 0, 1, 0, '0, "R3");
    chk_reg(32'h0010_0008, "R3");
    idle_n(7, 0, 12, 1, "R3");
    step(1, 0, 1, 1, 0, 0, '0, "R3");
    chk_reg(32'h0010_0008, "R3");

    // R10: zero thresholds
    step(1, 0, 1, 0, 0, 1, 32'h0, "R10");
    idle_n(4, 1, 0, 1, "R10");
    idle_n(4, 0, 0, 1, "R10");
    idle_n(3, 1, 1, 1, "R10");
    step(1, 0, 1, 1, 0, 0, '0, "R10");
    idle_n(3, 1, 0, 1, "R10");

    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule